// File: doc/BRIEF.md
# I3C Controller Target Table Register Bank

This block is the software-visible table in which an I3C controller keeps one record per attached target. A record has three 32-bit words. The first word holds the target's configuration. The second and third words hold the 48-bit Provisional ID and the target's two characteristic bytes. A device-control word sits next to the table and holds one active flag per record. Software reaches all of these words through a zero-wait-state APB slave port.

The controller core reads every record and every active flag through flat read-only outputs. When the core finishes a dynamic-address assignment, it pulses a strobe together with a 4-bit record index, and the matching active flag is set. Firmware can also set flags directly, which it does for targets given a static-to-dynamic address. It clears flags through write-one-to-clear bits after an address reset, or when a target has stopped acknowledging.

Top module: `devTableRegs`

## Requirements
- R1: After reset, every record word on the core outputs reads zero, every active flag is zero, and the device-control word reads zero.
- R2: Record n (0 to 11) begins at byte offset 0x080 + 16*n. The configuration word is at +0x0, the upper ID word at +0x4 (Provisional ID bits 47:16) and the lower word at +0x8 (ID bits 15:0 in 31:16, DCR in 15:8, BCR in 7:0). A write to a record that exists in the build stores all 32 bits. The stored value then reads back over APB and appears on the matching core output slice one cycle after the write.
- R3: The device-control word is at offset 0x040. It reads back the active flags in bits [NUM_ENTRIES-1:0], and every other bit reads zero, including the clear bits.
- R4: A pulse on assignValid with an index below NUM_ENTRIES sets that record's active flag on the next cycle. An index at or above NUM_ENTRIES changes no flag.
- R5: In a write to the device-control word, a one in bit i (i below NUM_ENTRIES) sets flag i. Zero bits leave their flags unchanged.
- R6: In a write to the device-control word, a one in bit 16+i clears flag i. Writing all of bits 27:16 clears every flag. If a single write both sets and clears a flag, the clear wins.
- R7: If a hardware assignment and a firmware clear hit the same record in the same cycle, the flag ends up set.
- R8: PREADY is always high, and each access completes in its access phase with no wait state.
- R9: PSLVERR is raised in the access phase for an address that is not word aligned, for the unused fourth word of a record, and for any offset outside the device-control word and the 0x080 to 0x13F window. A write that gets an error changes no state.
- R10: Records at or above NUM_ENTRIES but below 12 are mapped. They read as zero, give no error, and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error for unmapped or misaligned access |
| assignValid | input | 1 | Core strobe: dynamic address assigned |
| assignIdx | input | 4 | Record index for assignValid |
| entRr0 | output | 32*NUM_ENTRIES | Configuration words, record n at [32n+31:32n] |
| entRr1 | output | 32*NUM_ENTRIES | Upper Provisional ID words |
| entRr2 | output | 32*NUM_ENTRIES | Lower ID / DCR / BCR words |
| entActive | output | NUM_ENTRIES | Active flag per record |

## Verification
The hardest case to reach is a core assignment that lands on the same clock edge as a firmware clear of that same flag. The bench raises assignValid during the access phase of a device-control write, so both events are registered on one edge. A reference model runs every cycle and checks that the hardware set wins. The bench is built with fewer records than the address window holds, which makes the mapped but absent records observable. It also sends assignments with indices past the build size, and it mixes set and clear bits in a single write.

// File: rtl/devTablePkg.sv
package devTablePkg;
  localparam int MAX_SECTIONS = 12;
  localparam int SEC_W = $clog2(MAX_SECTIONS);
  localparam int CLR_LSB = 16;

  typedef enum logic [1:0] {
    RD_NONE    = 2'd0,
    RD_DEVCTRL = 2'd1,
    RD_WORD    = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic             wrWord;
    logic             wrDevCtrl;
    rdSel_e           rdSel;
    logic [SEC_W-1:0] sec;
    logic [1:0]       word;
  } tblStrobe_t;
endpackage

// File: rtl/devTableCtrl.sv
module devTableCtrl
  import devTablePkg::*;
#(
  parameter int NUM_ENTRIES = 12,
  parameter int ADDR_W      = 12,
  parameter int TABLE_BASE  = 'h080,
  parameter int DEVCTRL_OFF = 'h040
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output tblStrobe_t        strobe,
  output logic              pslverr,
  output logic              pready
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TABLE_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(TABLE_BASE + 16 * MAX_SECTIONS);
  localparam logic [ADDR_W-1:0] DEV_A  = ADDR_W'(DEVCTRL_OFF);

  logic access;
  logic aligned;
  logic isDev;
  logic inTable;
  logic wordOk;
  logic configured;
  logic [SEC_W-1:0] sec;

  always_comb begin
    access     = psel && penable;
    aligned    = (paddr[1:0] == 2'b00);
    isDev      = aligned && (paddr == DEV_A);
    inTable    = aligned && (paddr >= BASE_A) && (paddr < END_A);
    sec        = paddr[SEC_W+3:4] - BASE_A[SEC_W+3:4];
    wordOk     = inTable && (paddr[3:2] != 2'd3);
    configured = int'(sec) < NUM_ENTRIES;

    pready  = 1'b1;
    pslverr = access && !(isDev || wordOk);

    strobe.sec       = sec;
    strobe.word      = paddr[3:2];
    strobe.wrWord    = access && pwrite && wordOk && configured;
    strobe.wrDevCtrl = access && pwrite && isDev;
    if (!access || pwrite)
      strobe.rdSel = RD_NONE;
    else if (isDev)
      strobe.rdSel = RD_DEVCTRL;
    else if (wordOk && configured)
      strobe.rdSel = RD_WORD;
    else
      strobe.rdSel = RD_NONE;
  end
endmodule

// File: rtl/devTableData.sv
module devTableData
  import devTablePkg::*;
#(
  parameter int NUM_ENTRIES = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tblStrobe_t               strobe,
  input  logic [31:0]              pwdata,
  input  logic                     assignValid,
  input  logic [3:0]               assignIdx,
  output logic [31:0]              rdData,
  output logic [32*NUM_ENTRIES-1:0] entRr0,
  output logic [32*NUM_ENTRIES-1:0] entRr1,
  output logic [32*NUM_ENTRIES-1:0] entRr2,
  output logic [NUM_ENTRIES-1:0]   entActive
);
  localparam int PAD_W = 32 - NUM_ENTRIES;

  logic [NUM_ENTRIES-1:0] hwSet;
  logic [NUM_ENTRIES-1:0] fwSet;
  logic [NUM_ENTRIES-1:0] fwClr;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      hwSet[i] = assignValid && (int'(assignIdx) == i);
      fwSet[i] = strobe.wrDevCtrl && pwdata[i];
      fwClr[i] = strobe.wrDevCtrl && pwdata[CLR_LSB+i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entRr0    <= '0;
      entRr1    <= '0;
      entRr2    <= '0;
      entActive <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobe.wrWord && (int'(strobe.sec) == i)) begin
          case (strobe.word)
            2'd0:    entRr0[32*i +: 32] <= pwdata;
            2'd1:    entRr1[32*i +: 32] <= pwdata;
            2'd2:    entRr2[32*i +: 32] <= pwdata;
            default: ;
          endcase
        end
      end
      entActive <= ((entActive | fwSet) & ~fwClr) | hwSet;
    end
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      RD_DEVCTRL: rdData = {{PAD_W{1'b0}}, entActive};
      RD_WORD: begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
          if (int'(strobe.sec) == i) begin
            case (strobe.word)
              2'd0:    rdData = entRr0[32*i +: 32];
              2'd1:    rdData = entRr1[32*i +: 32];
              2'd2:    rdData = entRr2[32*i +: 32];
              default: rdData = '0;
            endcase
          end
        end
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/devTableRegs.sv
module devTableRegs
  import devTablePkg::*;
#(
  parameter int NUM_ENTRIES = 12,
  parameter int ADDR_W      = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic [ADDR_W-1:0]         paddr,
  input  logic [31:0]               pwdata,
  output logic [31:0]               prdata,
  output logic                      pready,
  output logic                      pslverr,
  input  logic                      assignValid,
  input  logic [3:0]                assignIdx,
  output logic [32*NUM_ENTRIES-1:0] entRr0,
  output logic [32*NUM_ENTRIES-1:0] entRr1,
  output logic [32*NUM_ENTRIES-1:0] entRr2,
  output logic [NUM_ENTRIES-1:0]    entActive
);
  tblStrobe_t strobe;

  devTableCtrl #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .strobe (strobe),
    .pslverr(pslverr),
    .pready (pready)
  );

  devTableData #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pwdata     (pwdata),
    .assignValid(assignValid),
    .assignIdx  (assignIdx),
    .rdData     (prdata),
    .entRr0     (entRr0),
    .entRr1     (entRr1),
    .entRr2     (entRr2),
    .entActive  (entActive)
  );
endmodule

// File: rtl/devTableChecker.sv
module devTableChecker #(
  parameter int NUM_ENTRIES = 12
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      psel,
  input logic                      penable,
  input logic                      pwrite,
  input logic                      pready,
  input logic                      pslverr,
  input logic                      assignValid,
  input logic [3:0]                assignIdx,
  input logic [32*NUM_ENTRIES-1:0] entRr0,
  input logic [32*NUM_ENTRIES-1:0] entRr1,
  input logic [32*NUM_ENTRIES-1:0] entRr2,
  input logic [NUM_ENTRIES-1:0]    entActive
);
  logic [NUM_ENTRIES-1:0] hwMask;
  logic wrAccess;

  always_comb begin
    hwMask = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      hwMask[i] = assignValid && (int'(assignIdx) == i);
    wrAccess = psel && penable && pwrite;
  end

  assert_pready_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    pready);

  assert_err_only_in_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    pslverr |-> (psel && penable));

  assert_hw_set_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hwMask != '0) |=> ((entActive & $past(hwMask)) == $past(hwMask)));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrAccess && !assignValid) |=> $stable(entActive));

  assert_words_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrAccess |=> ($stable(entRr0) && $stable(entRr1) && $stable(entRr2)));

  assert_err_write_inert_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrAccess && pslverr && !assignValid) |=>
      ($stable(entRr0) && $stable(entRr1) && $stable(entRr2) && $stable(entActive)));
endmodule

bind devTableRegs devTableChecker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .psel       (psel),
  .penable    (penable),
  .pwrite     (pwrite),
  .pready     (pready),
  .pslverr    (pslverr),
  .assignValid(assignValid),
  .assignIdx  (assignIdx),
  .entRr0     (entRr0),
  .entRr1     (entRr1),
  .entRr2     (entRr2),
  .entActive  (entActive)
);

// File: tb/devTableRegs_bench.sv
`timescale 1ns/1ps
module devTableRegs_bench;
  localparam int NUM = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic assignValid = 1'b0;
  logic [3:0] assignIdx = '0;
  logic [32*NUM-1:0] entRr0, entRr1, entRr2;
  logic [NUM-1:0] entActive;

  int nChecks = 0;
  int nFails = 0;
  int mAct[12];
  logic [31:0] mRr[12][3];

  always #2 clk = ~clk;

  devTableRegs #(.NUM_ENTRIES(NUM), .ADDR_W(12)) u_devTableRegs (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .assignValid(assignValid), .assignIdx(assignIdx),
    .entRr0(entRr0), .entRr1(entRr1), .entRr2(entRr2), .entActive(entActive)
  );

  task automatic check32(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Behavioural reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 12; i++) begin
        mAct[i] = 0;
        for (int w = 0; w < 3; w++) mRr[i][w] = '0;
      end
    end else begin
      if (psel && penable && pwrite) begin
        int a;
        a = int'(paddr);
        if (a == 'h040) begin
          for (int i = 0; i < NUM; i++) if (pwdata[i]) mAct[i] = 1;
          for (int i = 0; i < NUM; i++) if (pwdata[16+i]) mAct[i] = 0;
        end else if (a % 4 == 0 && a >= 'h080 && a < 'h140) begin
          int s, w;
          s = (a - 'h080) / 16;
          w = (a % 16) / 4;
          if (w < 3 && s < NUM) mRr[s][w] = pwdata;
        end
      end
      if (assignValid && int'(assignIdx) < NUM) mAct[assignIdx] = 1;
    end
  end

  // Per-cycle comparison of the core-facing outputs against the model
  always @(negedge clk) begin
    if (rstN) begin
      logic [NUM-1:0] expAct;
      for (int i = 0; i < NUM; i++) expAct[i] = (mAct[i] != 0);
      check32("R4/R5/R6 active flags", 32'(entActive), 32'(expAct));
      check32("R8 pready", 32'(pready), 32'd1);
      for (int i = 0; i < NUM; i++) begin
        check32("R2 cfg word out", entRr0[32*i +: 32], mRr[i][0]);
        check32("R2 id-high word out", entRr1[32*i +: 32], mRr[i][1]);
        check32("R2 id-low word out", entRr2[32*i +: 32], mRr[i][2]);
      end
    end
  end

  function automatic logic [32:0] expRead(int a);
    logic [31:0] v;
    v = '0;
    if (a % 4 != 0) return {1'b1, 32'h0};
    if (a == 'h040) begin
      for (int i = 0; i < NUM; i++) v[i] = (mAct[i] != 0);
      return {1'b0, v};
    end
    if (a >= 'h080 && a < 'h140) begin
      int s, w;
      s = (a - 'h080) / 16;
      w = (a % 16) / 4;
      if (w == 3) return {1'b1, 32'h0};
      if (s >= NUM) return {1'b0, 32'h0};
      return {1'b0, mRr[s][w]};
    end
    return {1'b1, 32'h0};
  endfunction

  task automatic apbRead(int a, string req);
    logic [32:0] e;
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = 12'(a);
    @(negedge clk);
    penable = 1'b1;
    #1;
    e = expRead(a);
    check32({req, " pslverr"}, 32'(pslverr), 32'(e[32]));
    if (!e[32]) check32({req, " prdata"}, prdata, e[31:0]);
    @(posedge clk);
    #0.5;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic apbWrite(int a, logic [31:0] d, bit expErr, string req,
                          bit withAssign = 1'b0, int idx = 0);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = 12'(a); pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    if (withAssign) begin assignValid = 1'b1; assignIdx = 4'(idx); end
    #1;
    check32({req, " pslverr"}, 32'(pslverr), 32'(expErr));
    @(posedge clk);
    #0.5;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; assignValid = 1'b0;
  endtask

  task automatic hwAssign(int idx);
    @(negedge clk);
    assignValid = 1'b1; assignIdx = 4'(idx);
    @(posedge clk);
    #0.5;
    assignValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #0.5 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check32("R1 active after reset", 32'(entActive), 32'h0);
    check32("R1 cfg words after reset", entRr0[31:0] | entRr0[32*(NUM-1) +: 32], 32'h0);
    apbRead('h040, "R1 devctrl after reset");

    // R2: record words, mapping and field layout
    apbWrite('h080, 32'h1234_5678, 1'b0, "R2 rec0 cfg");
    apbWrite('h084, 32'hCAFE_F00D, 1'b0, "R2 rec0 id-high");
    apbWrite('h088, {16'hA1B2, 8'hC3, 8'hD4}, 1'b0, "R2 rec0 id-low");
    apbWrite('h0D4, 32'h0BAD_BEEF, 1'b0, "R2 rec5 id-high");
    apbWrite('h118, 32'h5555_AAAA, 1'b0, "R2 rec9 id-low");
    apbRead('h080, "R2 rec0 cfg");
    apbRead('h084, "R2 rec0 id-high");
    apbRead('h088, "R2 rec0 id-low");
    apbRead('h0D4, "R2 rec5 id-high");
    apbRead('h118, "R2 rec9 id-low");
    @(negedge clk);
    check32("R2 rec0 BCR on output", 32'(entRr2[7:0]), 32'hD4);
    check32("R2 rec9 fixed value", entRr2[32*9 +: 32], 32'h5555_AAAA);

    // R9: errors and inert erroneous writes
    apbRead('h08C, "R9 fourth word read");
    apbWrite('h0DC, 32'hFFFF_FFFF, 1'b1, "R9 fourth word write");
    apbRead('h200, "R9 out of window");
    apbRead('h07C, "R9 below window");
    apbRead('h081, "R9 misaligned");
    apbWrite('h085, 32'h0, 1'b1, "R9 misaligned write");
    apbRead('h084, "R9 word intact after misaligned write");

    // R10: absent records in the window
    apbWrite('h120, 32'hDEAD_0001, 1'b0, "R10 absent rec10 write");
    apbRead('h120, "R10 absent rec10 read");
    apbRead('h138, "R10 absent rec11 read");

    // R4: hardware assignment
    hwAssign(3);
    @(negedge clk);
    check32("R4 rec3 active", 32'(entActive[3]), 32'd1);
    hwAssign(11);
    hwAssign(15);
    @(negedge clk);
    check32("R4 out-of-range index ignored", 32'(entActive), 32'h008);

    // R5: firmware set; R3: readback with clear bits reading zero
    apbWrite('h040, 32'h0000_00F0 | 32'hF000_F000, 1'b0, "R5 fw set");
    apbRead('h040, "R3 devctrl readback");
    @(negedge clk);
    check32("R5 flags after set", 32'(entActive), 32'h0F8);

    // R6: targeted clear, set+clear in one write, broadcast clear
    apbWrite('h040, 32'h0010_0000, 1'b0, "R6 clear rec4");
    apbWrite('h040, 32'h0001_0001, 1'b0, "R6 set and clear rec0");
    @(negedge clk);
    check32("R6 flags after clears", 32'(entActive), 32'h0E8);
    apbWrite('h040, 32'h0FFF_0000, 1'b0, "R6 broadcast clear");
    @(negedge clk);
    check32("R6 all cleared", 32'(entActive), 32'h0);

    // R7: hardware set and firmware clear on the same edge
    apbWrite('h040, 32'h0000_0006, 1'b0, "R7 preset");
    apbWrite('h040, 32'h0006_0000, 1'b0, "R7 clear with assign", 1'b1, 2);
    @(negedge clk);
    check32("R7 hw set wins", 32'(entActive), 32'h004);
    apbRead('h040, "R7 devctrl readback");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule